// File: doc/BRIEF.md
# Interrupt Cause Register Controller

This block collects hardware event pulses into three 32-bit cause banks: receive, transmit and miscellaneous. Each bank has a cause register, a mask, and a clear-mode word that picks for each bit whether a read clears it or a written 1 clears it. Mask bits are set and cleared through two separate strobe registers, so software never needs a read-modify-write. A readable mask-value register shows the current mask.

A summary register holds one sticky bit per bank. A bit is set while its bank has any cause bit that is pending and not masked. Reading the summary clears it. A software mask then gates the summary into a single level interrupt line. Software reads and writes all registers through a simple register bus with one cycle of read latency.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause, clear-mode and summary register is zero, every bank mask and the summary mask are all ones, `rdata_o` is zero and `irq_o` is low.
- R2: A 1 on a bit of `rx_evt_i`, `tx_evt_i` or `misc_evt_i` in a cycle sets that cause bit at the next edge. The bit then holds until it is cleared. Masking does not stop capture. Bank bases are 0x000 (receive), 0x020 (transmit) and 0x040 (miscellaneous). The cause register is at bank offset 0x00.
- R3: A write to a cause register clears each bit where the write data is 1 and the clear-mode bit (offset 0x10, read/write) is 0. Cause bits whose clear-mode bit is 1 are not affected by writes.
- R4: A read of a cause register returns the value held before the access. Every bit whose clear-mode bit is 1 is cleared at the same edge. Bits whose clear-mode bit is 0 keep their value.
- R5: When an event sets a bit in the same cycle that a read or a write clears it, the bit ends up set.
- R6: A write to offset 0x08 sets the mask bits where the data is 1. A write to offset 0x0C clears the mask bits where the data is 1. Offset 0x04 reads the current mask and ignores writes. Offsets 0x08 and 0x0C read as zero.
- R7: The summary register at 0x100 has bit 0 for receive, bit 1 for transmit and bit 2 for miscellaneous. A bit is set at the edge after a cycle in which its bank has a cause bit that is 1 with mask bit 0. Bits 31:3 read as zero.
- R8: A read of 0x100 clears the summary at that edge, except for banks that are pending in that same cycle.
- R9: `irq_o` is high exactly when some summary bit is 1 and its bit in the summary mask (0x104, read/write, all 32 bits stored) is 0.
- R10: `rdata_o` is loaded at the edge where `reg_re_i` is high and holds otherwise. Addresses that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 32 | Receive event pulses |
| tx_evt_i | input | 32 | Transmit event pulses |
| misc_evt_i | input | 32 | Miscellaneous event pulses |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 32 | Write data |
| reg_re_i | input | 1 | Read enable |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt line, level |

## Verification
The hardest situation to reach is a collision: an event lands on a bit in the same cycle that a clear-on-read access or a write-1-to-clear access hits it. The same applies to a summary read that coincides with a bank still pending. Random stimulus fires sparse event bits on every cycle and mixes clear-mode words. Directed steps add the two collisions explicitly. Every read and the interrupt line are compared with a bench model that is updated cycle by cycle.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int NUM_BANKS = 3;
  localparam int ADDR_W    = 12;

  localparam logic [4:0] OFF_CAUSE = 5'h00;
  localparam logic [4:0] OFF_MVAL  = 5'h04;
  localparam logic [4:0] OFF_MSET  = 5'h08;
  localparam logic [4:0] OFF_MCLR  = 5'h0C;
  localparam logic [4:0] OFF_MODE  = 5'h10;

  localparam logic [ADDR_W-1:0] ADDR_PCAUSE = 12'h100;
  localparam logic [ADDR_W-1:0] ADDR_PMASK  = 12'h104;

  typedef enum logic [1:0] {
    BANK_RX   = 2'd0,
    BANK_TX   = 2'd1,
    BANK_MISC = 2'd2
  } bank_e;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          sel_i,
  input  logic [4:0]    off_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cause_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] mode_o,
  output logic          pend_o
);
  logic [DW-1:0] cause_q, mask_q, mode_q, clr;

  always_comb begin
    clr = '0;
    if (sel_i && we_i && off_i == OFF_CAUSE) clr |= wdata_i & ~mode_q;
    if (sel_i && re_i && off_i == OFF_CAUSE) clr |= mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= '1;
      mode_q  <= '0;
    end else begin
      // set has priority over any clear
      cause_q <= (cause_q & ~clr) | evt_i;
      if (sel_i && we_i) begin
        case (off_i)
          OFF_MSET: mask_q <= mask_q | wdata_i;
          OFF_MCLR: mask_q <= mask_q & ~wdata_i;
          OFF_MODE: mode_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;
  assign pend_o  = |(cause_q & ~mask_q);
endmodule

// File: rtl/irq_cause_summary.sv
module irq_cause_summary #(
  parameter int NB = 3,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] pend_i,
  input  logic          rd_i,
  input  logic          pm_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NB-1:0] pc_o,
  output logic [DW-1:0] pmask_o,
  output logic          irq_o
);
  logic [NB-1:0] pc_q;
  logic [DW-1:0] pmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      pmask_q <= '1;
    end else begin
      pc_q <= (pc_q & ~{NB{rd_i}}) | pend_i;
      if (pm_we_i) pmask_q <= wdata_i;
    end
  end

  assign pc_o    = pc_q;
  assign pmask_o = pmask_q;
  assign irq_o   = |(pc_q & ~pmask_q[NB-1:0]);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     rx_evt_i,
  input  logic [DW-1:0]     tx_evt_i,
  input  logic [DW-1:0]     misc_evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic              reg_re_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  localparam int NB = NUM_BANKS;

  logic [NB-1:0][DW-1:0] evt_w, cause_w, mask_w, mode_w;
  logic [NB-1:0]         bank_sel, pend_w, pc_w;
  logic [DW-1:0]         pmask_w, rd_val, rdata_q;
  logic [4:0]            off;

  assign evt_w[BANK_RX]   = rx_evt_i;
  assign evt_w[BANK_TX]   = tx_evt_i;
  assign evt_w[BANK_MISC] = misc_evt_i;
  assign off = reg_addr_i[4:0];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_sel[b] = (reg_addr_i[11:8] == 4'h0) && (reg_addr_i[7:5] == 3'(b));
    irq_cause_bank #(.DW(DW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_w[b]),
      .sel_i   (bank_sel[b]),
      .off_i   (off),
      .we_i    (reg_we_i),
      .re_i    (reg_re_i),
      .wdata_i (reg_wdata_i),
      .cause_o (cause_w[b]),
      .mask_o  (mask_w[b]),
      .mode_o  (mode_w[b]),
      .pend_o  (pend_w[b])
    );
  end

  irq_cause_summary #(.NB(NB), .DW(DW)) u_sum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_w),
    .rd_i    (reg_re_i && reg_addr_i == ADDR_PCAUSE),
    .pm_we_i (reg_we_i && reg_addr_i == ADDR_PMASK),
    .wdata_i (reg_wdata_i),
    .pc_o    (pc_w),
    .pmask_o (pmask_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NB; b++) begin
      if (bank_sel[b]) begin
        case (off)
          OFF_CAUSE: rd_val = cause_w[b];
          OFF_MVAL:  rd_val = mask_w[b];
          OFF_MODE:  rd_val = mode_w[b];
          default: ;
        endcase
      end
    end
    if (reg_addr_i == ADDR_PCAUSE) rd_val = DW'(pc_w);
    if (reg_addr_i == ADDR_PMASK)  rd_val = pmask_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_val;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_cause_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [DW-1:0]     reg_wdata_i,
  input logic [DW-1:0]     rx_evt_i,
  input logic              irq_o,
  input logic [DW-1:0]     rx_cause_i,
  input logic [DW-1:0]     rx_mask_i,
  input logic [2:0]        pend_i,
  input logic [2:0]        pc_i,
  input logic [DW-1:0]     pmask_i
);
  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_evt_i != '0) |=> ((rx_cause_i & $past(rx_evt_i)) == $past(rx_evt_i))); // R5

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 12'(OFF_MSET)) |=>
      ((rx_mask_i & $past(reg_wdata_i)) == $past(reg_wdata_i))); // R6

  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 12'(OFF_MCLR)) |=>
      ((rx_mask_i & $past(reg_wdata_i)) == '0)); // R6

  AST_SUM_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pc_i & ~$past(pc_i) & ~$past(pend_i)) == '0)); // R7

  AST_SUM_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == ADDR_PCAUSE && pend_i == '0) |=> (pc_i == '0)); // R8

  AST_IRQ_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmask_i[2:0] == 3'b111) |-> !irq_o); // R9
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_wdata_i (reg_wdata_i),
  .rx_evt_i    (rx_evt_i),
  .irq_o       (irq_o),
  .rx_cause_i  (cause_w[0]),
  .rx_mask_i   (mask_w[0]),
  .pend_i      (pend_w),
  .pc_i        (pc_w),
  .pmask_i     (pmask_w)
);

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] rx_evt = '0, tx_evt = '0, misc_evt = '0, wdata = '0, rdata;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0, irq;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] m_cause [3], m_mask [3], m_mode [3];
  logic [31:0] m_pm;
  logic [2:0]  m_pc;

  always #4 clk = ~clk;

  irq_cause_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_evt_i(rx_evt), .tx_evt_i(tx_evt),
    .misc_evt_i(misc_evt), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_re_i(re), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [11:0] a);
    logic [31:0] v = '0;
    if (a == 12'h100) v = {29'd0, m_pc};
    else if (a == 12'h104) v = m_pm;
    else if (a[11:8] == 4'h0 && a[7:5] < 3'd3) begin
      case (a[4:0])
        5'h00: v = m_cause[a[6:5]];
        5'h04: v = m_mask[a[6:5]];
        5'h10: v = m_mode[a[6:5]];
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'h100) return "R8";
    if (a == 12'h104) return "R9";
    if (a[11:8] != 4'h0 || a[7:5] > 3'd2) return "R10";
    case (a[4:0])
      5'h00: return "R4";
      5'h10: return "R3";
      5'h04, 5'h08, 5'h0C: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic cyc(input logic [31:0] er, et, em, input logic [11:0] a,
                     input logic w, input logic [31:0] wd, input logic r);
    logic [31:0] nc [3], nm [3], nmd [3], evt [3], exp_rd;
    logic [2:0]  pend;
    rx_evt = er; tx_evt = et; misc_evt = em; addr = a; we = w; wdata = wd; re = r;
    evt[0] = er; evt[1] = et; evt[2] = em;
    exp_rd = model_rd(a);
    for (int b = 0; b < 3; b++) begin
      logic        hit = (a[11:8] == 4'h0) && (a[7:5] == 3'(b));
      logic [31:0] clr = '0;
      if (hit && w && a[4:0] == 5'h00) clr |= wd & ~m_mode[b];
      if (hit && r && a[4:0] == 5'h00) clr |= m_mode[b];
      nc[b] = (m_cause[b] & ~clr) | evt[b];
      nm[b] = m_mask[b]; nmd[b] = m_mode[b];
      if (hit && w && a[4:0] == 5'h08) nm[b] = m_mask[b] | wd;
      if (hit && w && a[4:0] == 5'h0C) nm[b] = m_mask[b] & ~wd;
      if (hit && w && a[4:0] == 5'h10) nmd[b] = wd;
      pend[b] = |(m_cause[b] & ~m_mask[b]);
    end
    @(posedge clk);
    for (int b = 0; b < 3; b++) begin
      m_cause[b] = nc[b]; m_mask[b] = nm[b]; m_mode[b] = nmd[b];
    end
    m_pc = ((r && a == 12'h100) ? 3'b000 : m_pc) | pend;
    if (w && a == 12'h104) m_pm = wd;
    @(negedge clk);
    check("R9", {31'd0, irq}, {31'd0, |(m_pc & ~m_pm[2:0])});
    if (r) check(tag_of(a), rdata, exp_rd);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cyc('0, '0, '0, a, 1'b1, d, 1'b0);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    cyc('0, '0, '0, a, 1'b0, '0, 1'b1);
    check(req, rdata, exp);
  endtask

  function automatic logic [11:0] pick_addr();
    int          i = int'($urandom_range(0, 17));
    logic [4:0]  o;
    if (i == 15) return 12'h100;
    if (i == 16) return 12'h104;
    if (i == 17) return 12'h0F0;
    case (i % 5)
      0: o = 5'h00; 1: o = 5'h04; 2: o = 5'h08; 3: o = 5'h0C; default: o = 5'h10;
    endcase
    return {4'h0, 3'(i / 5), o};
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < 3; b++) begin
      m_cause[b] = '0; m_mask[b] = '1; m_mode[b] = '0;
    end
    m_pm = '1; m_pc = '0;
    #20;
    check("R1", rdata, '0);
    check("R1", {31'd0, irq}, '0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd(12'h024, 32'hFFFF_FFFF, "R1");
    rd(12'h104, 32'hFFFF_FFFF, "R1");
    rd(12'h040, 32'h0, "R1");
    // R2: capture under full mask
    cyc(32'h8, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    rd(12'h000, 32'h8, "R2");
    check("R2", {31'd0, irq}, '0);
    // R3: write-1-to-clear, then a clear-on-read bit ignores writes
    wr(12'h000, 32'h8);
    rd(12'h000, 32'h0, "R3");
    wr(12'h010, 32'h10);
    cyc(32'h10, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    wr(12'h000, 32'h10);
    rd(12'h000, 32'h10, "R3");
    rd(12'h000, 32'h0, "R4");
    // R4: mixed modes on one read
    cyc(32'h11, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    rd(12'h000, 32'h11, "R4");
    rd(12'h000, 32'h01, "R4");
    wr(12'h000, 32'h1);
    // R5: event collides with clear-on-read and with write-1-to-clear
    cyc(32'h10, '0, '0, 12'h000, 1'b0, '0, 1'b1);
    rd(12'h000, 32'h10, "R5");
    cyc(32'h4, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    cyc(32'h4, '0, '0, 12'h000, 1'b1, 32'h4, 1'b0);
    rd(12'h000, 32'h4, "R5");
    wr(12'h000, 32'h4);
    // R6: mask strobes
    wr(12'h02C, 32'h1);
    rd(12'h024, 32'hFFFF_FFFE, "R6");
    wr(12'h024, 32'h0);
    rd(12'h024, 32'hFFFF_FFFE, "R6");
    rd(12'h028, 32'h0, "R6");
    // R7/R9: transmit bit 0 reaches the line
    cyc('0, 32'h1, '0, 12'h0, 1'b0, '0, 1'b0);
    wr(12'h104, 32'hFFFF_FFF8);
    check("R9", {31'd0, irq}, 32'h1);
    rd(12'h100, 32'h2, "R7");
    // R8: read while still pending keeps the bit, clears once cause is gone
    wr(12'h020, 32'h1);
    rd(12'h100, 32'h2, "R8");
    rd(12'h100, 32'h0, "R8");
    check("R9", {31'd0, irq}, '0);
    rd(12'h0F0, 32'h0, "R10");
    cyc('0, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    check("R10", rdata, 32'h0);
    // random phase
    for (int k = 0; k < 4000; k++) begin
      logic [11:0] a = pick_addr();
      logic        w = ($urandom_range(0, 2) == 0);
      logic [31:0] d = ($urandom_range(0, 5) == 0) ? 32'hFFFF_FFFF : $urandom();
      if (w && a == 12'h104 && $urandom_range(0, 1) == 0) d = 32'hFFFF_FFF8;
      cyc($urandom() & $urandom() & $urandom() & $urandom(),
          $urandom() & $urandom() & $urandom() & $urandom(),
          $urandom() & $urandom() & $urandom() & $urandom(),
          a, w, d, ($urandom_range(0, 1) == 0));
    end
    cyc('0, '0, '0, 12'h0, 1'b0, '0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule